// File: doc/BRIEF.md
# Variable-Frequency Pulse Controller with Feed-Forward On-Time

This block drives the gate of an external switching transistor with one pulse per switching period. Output regulation is achieved by moving the switching frequency, not the duty cycle. An external averaging comparator reports whether the averaged sense value is below or above its reference. In the regulating phase, each period end shortens the period (raising the frequency) when the average is low, lengthens it when the average is high, and keeps it when neither or both flags are set. Every step equals the present period shifted right by a parameter, with a minimum of one count. Because the step scales with the period, the frequency moves exponentially during a ramp.

The width of each pulse comes from feed-forward of the line voltage code. At the start of every period a sequential restoring divider computes a fixed constant divided by the line code. The result is limited to half of the current period, and the pulse begins a fixed number of cycles into the period, once the quotient is ready.

A supply-voltage code controls a lockout with hysteresis. While the block is locked out, the gate is low and the period is at its longest. After release the block runs a fixed number of periods at the longest period before feedback may act.

Top module: `vfreq_pwm`

## Requirements
- R1: During and after reset, and whenever locked out, `gate_o` is 0, `mode_o` is 0 (locked) and `period_o` equals PERIOD_MAX (400).
- R2: A locked block is released only when `supply_code` is strictly greater than UV_RISE (128, i.e. 8.0 V at 16 codes per volt). Any code from 0 to 128 leaves it locked.
- R3: A running block locks out only when `supply_code` is strictly below UV_FALL (120, 7.5 V). Codes from 120 upward keep it running.
- R4: When lockout asserts, on the next clock edge the gate is 0, `mode_o` is 0 and `period_o` is PERIOD_MAX. The start-up count is cleared, so a later release replays the full start-up hold.
- R5: After release, `mode_o` is 1 (start-up) for HOLD_CYC (16) periods, all of length PERIOD_MAX, whatever the flags. From the next period on, `mode_o` is 2 (regulating).
- R6: In regulating mode with only `avg_low` set at a period end, the next period is p - max(p>>3, 1), with a floor of PERIOD_MIN (32).
- R7: In regulating mode with only `avg_high` set at a period end, the next period is p + max(p>>3, 1), with a ceiling of PERIOD_MAX.
- R8: In regulating mode with neither flag or both flags set at a period end, the period does not change.
- R9: The gate is high for exactly min(VS_CONST / max(line_code, 1), p >> 1) consecutive cycles per period, where VS_CONST is 4000, p is the current period, and `line_code` is sampled at the period's first cycle.
- R10: Gate rising edges are spaced by exactly the length of the period in which the earlier edge occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_code | input | SUP_W (10) | Digitised supply voltage used for lockout |
| line_code | input | VIN_W (8) | Digitised line voltage used for feed-forward |
| avg_low | input | 1 | Averaged sense value is below the reference |
| avg_high | input | 1 | Averaged sense value is above the reference |
| gate_o | output | 1 | Gate drive pulse train |
| period_o | output | PER_W (16) | Current switching period in clock cycles |
| mode_o | output | 2 | 0 locked, 1 start-up, 2 regulating |

## Verification
The hardest state to reach from the ports is a lockout that arrives in the middle of a pulse after regulation has already moved the period away from its maximum. Reaching it requires a full start-up hold followed by a ramp. The stimulus releases the block, rides the frequency ramp down to the period floor, and climbs back through the hold and ceiling cases. It then removes the supply on the very cycle a gate rise is seen and checks that the whole start-up hold replays. The half-period clamp on the on-time is exercised both by sweeping the line code at the longest period and by measuring pulses at the shortest period.

// File: rtl/vfreq_pkg.sv
package vfreq_pkg;
   typedef enum logic [1:0] {
      ST_LOCK  = 2'd0,
      ST_START = 2'd1,
      ST_REG   = 2'd2
   } vf_state_e;
endpackage

// File: rtl/supply_guard.sv
module supply_guard #(
   parameter int SUP_W   = 10,
   parameter int UV_RISE = 128,
   parameter int UV_FALL = 120
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUP_W-1:0] sup,
   output logic             ok_nxt,
   output logic             ok
);
   localparam logic [SUP_W-1:0] RISE_C = SUP_W'(UV_RISE);
   localparam logic [SUP_W-1:0] FALL_C = SUP_W'(UV_FALL);

   initial begin
      assert (UV_FALL < UV_RISE) else $error("falling threshold must sit below rising threshold");
      assert (UV_RISE < (1 << SUP_W)) else $error("rising threshold exceeds code range");
   end

   always_comb begin
      if (ok) ok_nxt = (sup >= FALL_C);
      else    ok_nxt = (sup > RISE_C);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ok <= 1'b0;
      else        ok <= ok_nxt;
   end

   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ok && sup > RISE_C) |=> ok);
   p_no_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ok && sup <= RISE_C) |=> !ok);
   p_keep_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && sup >= FALL_C) |=> ok);
endmodule

// File: rtl/period_track.sv
module period_track #(
   parameter int PER_W      = 16,
   parameter int PERIOD_MIN = 32,
   parameter int PERIOD_MAX = 400,
   parameter int STEP_SHIFT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  logic             faster,
   input  logic             slower,
   output logic [PER_W-1:0] per
);
   localparam logic [PER_W:0]   MIN_X = (PER_W+1)'(PERIOD_MIN);
   localparam logic [PER_W:0]   MAX_X = (PER_W+1)'(PERIOD_MAX);
   localparam logic [PER_W-1:0] MAX_C = PER_W'(PERIOD_MAX);

   initial begin
      assert (PERIOD_MIN > 0 && PERIOD_MIN <= PERIOD_MAX) else $error("bad period limits");
      assert (PERIOD_MAX < (1 << PER_W)) else $error("period ceiling exceeds width");
      assert (STEP_SHIFT >= 0 && STEP_SHIFT < PER_W) else $error("bad step shift");
   end

   logic [PER_W-1:0] step;
   logic [PER_W:0]   dn_v, up_v;
   logic [PER_W-1:0] nxt;

   always_comb begin
      step = per >> STEP_SHIFT;
      if (step == '0) step = PER_W'(1);
      dn_v = {1'b0, per} - {1'b0, step};
      up_v = {1'b0, per} + {1'b0, step};
      nxt  = per;
      if (faster && !slower)      nxt = (dn_v < MIN_X) ? MIN_X[PER_W-1:0] : dn_v[PER_W-1:0];
      else if (slower && !faster) nxt = (up_v > MAX_X) ? MAX_C : up_v[PER_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   per <= MAX_C;
      else if (clr) per <= MAX_C;
      else if (upd) per <= nxt;
   end

   p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, per} >= MIN_X) && ({1'b0, per} <= MAX_X));
   p_faster_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && faster && !slower && !clr) |=> per <= $past(per));
   p_slower_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && slower && !faster && !clr) |=> per >= $past(per));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && (faster == slower) && !clr) |=> per == $past(per));
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> per == MAX_C);
endmodule

// File: rtl/recip_div.sv
module recip_div #(
   parameter int N_W      = 12,
   parameter int D_W      = 8,
   parameter int DIVIDEND = 4000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [D_W-1:0] divisor,
   output logic           busy,
   output logic [N_W-1:0] quo
);
   localparam int CW = $clog2(N_W + 1);
   localparam logic [N_W-1:0] DIVIDEND_C = N_W'(DIVIDEND);

   initial begin
      assert (N_W >= 2) else $error("quotient too narrow");
      assert (DIVIDEND < (1 << N_W)) else $error("dividend exceeds quotient width");
   end

   logic [D_W:0]   rem;
   logic [D_W-1:0] dv;
   logic [CW-1:0]  left;
   logic [D_W:0]   rem_sh;
   logic           fits;

   always_comb begin
      rem_sh = {rem[D_W-1:0], quo[N_W-1]};
      fits   = (rem_sh >= {1'b0, dv});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         rem  <= '0;
         quo  <= '0;
         dv   <= D_W'(1);
         left <= '0;
      end else if (start) begin
         busy <= 1'b1;
         rem  <= '0;
         quo  <= DIVIDEND_C;
         dv   <= (divisor == '0) ? D_W'(1) : divisor;
         left <= CW'(N_W);
      end else if (busy) begin
         rem  <= fits ? (rem_sh - {1'b0, dv}) : rem_sh;
         quo  <= {quo[N_W-2:0], fits};
         left <= left - CW'(1);
         busy <= (left != CW'(1));
      end
   end

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   p_rem_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> rem < {1'b0, dv});
endmodule

// File: rtl/vfreq_pwm.sv
module vfreq_pwm
   import vfreq_pkg::*;
#(
   parameter int SUP_W      = 10,
   parameter int UV_RISE    = 128,
   parameter int UV_FALL    = 120,
   parameter int VIN_W      = 8,
   parameter int PER_W      = 16,
   parameter int PERIOD_MIN = 32,
   parameter int PERIOD_MAX = 400,
   parameter int STEP_SHIFT = 3,
   parameter int HOLD_CYC   = 16,
   parameter int VS_CONST   = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUP_W-1:0] supply_code,
   input  logic [VIN_W-1:0] line_code,
   input  logic             avg_low,
   input  logic             avg_high,
   output logic             gate_o,
   output logic [PER_W-1:0] period_o,
   output logic [1:0]       mode_o
);
   localparam int Q_W  = $clog2(VS_CONST + 1);
   localparam int LAT  = Q_W + 2;
   localparam int HC_W = $clog2(HOLD_CYC + 1);
   localparam logic [PER_W-1:0] LAT_C  = PER_W'(LAT);
   localparam logic [PER_W-1:0] MAX_C  = PER_W'(PERIOD_MAX);
   localparam logic [HC_W-1:0]  HOLD_L = HC_W'(HOLD_CYC - 1);

   initial begin
      assert (HOLD_CYC >= 1) else $error("hold count must be at least one");
      assert (Q_W <= PER_W) else $error("quotient wider than period");
      assert (PERIOD_MIN >= 2 * LAT + 2) else $error("shortest period cannot fit divider latency and pulse");
   end

   vf_state_e        state;
   logic [PER_W-1:0] cnt;
   logic [HC_W-1:0]  hold;
   logic             gate_q;
   logic             ok_nxt, ok;
   logic [PER_W-1:0] per;
   logic             div_busy;
   logic [Q_W-1:0]   quo;
   logic             running, period_end, upd, div_start, in_win;
   logic [PER_W-1:0] half, quo_x, ton;

   supply_guard #(.SUP_W(SUP_W), .UV_RISE(UV_RISE), .UV_FALL(UV_FALL)) u_guard (
      .clk(clk), .rst_n(rst_n), .sup(supply_code), .ok_nxt(ok_nxt), .ok(ok));

   period_track #(.PER_W(PER_W), .PERIOD_MIN(PERIOD_MIN), .PERIOD_MAX(PERIOD_MAX),
                  .STEP_SHIFT(STEP_SHIFT)) u_per (
      .clk(clk), .rst_n(rst_n), .clr(!ok_nxt), .upd(upd),
      .faster(avg_low), .slower(avg_high), .per(per));

   recip_div #(.N_W(Q_W), .D_W(VIN_W), .DIVIDEND(VS_CONST)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .divisor(line_code),
      .busy(div_busy), .quo(quo));

   always_comb begin
      running    = (state != ST_LOCK);
      period_end = running && (cnt == per - PER_W'(1));
      upd        = period_end && (state == ST_REG);
      div_start  = running && (cnt == '0);
      half       = per >> 1;
      quo_x      = PER_W'(quo);
      ton        = (quo_x > half) ? half : quo_x;
      in_win     = (cnt >= LAT_C) && ({1'b0, cnt} < ({1'b0, LAT_C} + {1'b0, ton}));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_LOCK;
         cnt    <= '0;
         hold   <= '0;
         gate_q <= 1'b0;
      end else if (!ok_nxt) begin
         state  <= ST_LOCK;
         cnt    <= '0;
         hold   <= '0;
         gate_q <= 1'b0;
      end else begin
         gate_q <= running && in_win;
         if (state == ST_LOCK) begin
            state <= ST_START;
            cnt   <= '0;
         end else if (period_end) begin
            cnt <= '0;
            if (state == ST_START) begin
               if (hold == HOLD_L) begin
                  state <= ST_REG;
                  hold  <= '0;
               end else begin
                  hold <= hold + HC_W'(1);
               end
            end
         end else begin
            cnt <= cnt + PER_W'(1);
         end
      end
   end

   assign gate_o   = gate_q;
   assign period_o = per;
   assign mode_o   = state;

   p_locked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOCK) |-> (!gate_q && per == MAX_C));
   p_drop_on_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !ok_nxt) |=> (!gate_q && state == ST_LOCK));
   p_start_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START) |-> per == MAX_C);
   p_quotient_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == LAT_C) |-> !div_busy);
   p_gate_only_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gate_q |-> running);
   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> cnt < per);
endmodule

// File: tb/sim_vfreq_pwm.sv
module sim_vfreq_pwm;
   localparam int CLK_PER = 10;
   localparam int PMIN  = 32;
   localparam int PMAX  = 400;
   localparam int HOLD  = 16;
   localparam int VS    = 4000;
   localparam int RISE  = 128;
   localparam int FALL  = 120;
   localparam int LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] sup = '0;
   logic [7:0] vin = 8'd100;
   logic       lo = 1'b0, hi = 1'b0;
   logic       gate_o;
   logic [15:0] period_o;
   logic [1:0] mode_o;

   int n_cmp = 0, n_bad = 0;
   int cyc = 0;
   bit done = 0;
   int vin_eff = 100;
   int t_prev = 0, prev_per = 0;
   bit have_prev = 0;

   always #(CLK_PER/2) clk = ~clk;

   vfreq_pwm u0 (
      .clk(clk), .rst_n(rst_n), .supply_code(sup), .line_code(vin),
      .avg_low(lo), .avg_high(hi), .gate_o(gate_o), .period_o(period_o), .mode_o(mode_o));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > LIMIT && !done) begin
         done = 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog (all R) actual=%0d expected<%0d", cyc, LIMIT);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic check(input bit good, input string req, input int act, input int exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_ton(input int v, input int p);
      int d, q, h;
      d = (v == 0) ? 1 : v;
      q = VS / d;
      h = p / 2;
      return (q > h) ? h : q;
   endfunction

   function automatic int dn(input int p);
      int s, r;
      s = p >> 3; if (s == 0) s = 1;
      r = p - s;
      return (r < PMIN) ? PMIN : r;
   endfunction

   function automatic int up(input int p);
      int s, r;
      s = p >> 3; if (s == 0) s = 1;
      r = p + s;
      return (r > PMAX) ? PMAX : r;
   endfunction

   task automatic wait_rise(input string tag);
      int guard = 0;
      while (gate_o !== 1'b1 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      if (gate_o !== 1'b1) check(1'b0, tag, 0, 1);
   endtask

   task automatic next_pulse(input int exp_per, input int exp_mode, input string tag);
      int t_now, run;
      wait_rise(tag);
      t_now = cyc;
      check(int'(mode_o) == exp_mode, {tag, " mode"}, int'(mode_o), exp_mode);
      check(int'(period_o) == exp_per, {tag, " period"}, int'(period_o), exp_per);
      if (have_prev)
         check(t_now - t_prev == prev_per, "R10 rise spacing", t_now - t_prev, prev_per);
      run = 0;
      while (gate_o === 1'b1 && run < 1000) begin
         run++;
         @(negedge clk);
      end
      check(run == exp_ton(vin_eff, exp_per), "R9 on-time", run, exp_ton(vin_eff, exp_per));
      t_prev = t_now;
      prev_per = exp_per;
      have_prev = 1;
   endtask

   task automatic run_hold(input string tag);
      for (int k = 1; k <= HOLD; k++) next_pulse(PMAX, 1, {tag, " R5 hold"});
      next_pulse(PMAX, 2, {tag, " R5 enter regulation"});
   endtask

   initial begin
      int p;
      bit released;
      repeat (3) @(negedge clk);
      check(gate_o == 1'b0, "R1 gate in reset", gate_o, 0);
      check(mode_o == 2'd0, "R1 mode in reset", mode_o, 0);
      check(int'(period_o) == PMAX, "R1 period in reset", period_o, PMAX);
      rst_n = 1'b1;
      @(negedge clk);
      check(mode_o == 2'd0, "R1 mode after reset", mode_o, 0);

      released = 0;
      for (int c = 100; c <= 135; c++) begin
         sup = 10'(c);
         @(negedge clk);
         if (c > RISE) released = 1;
         check((mode_o != 2'd0) == released, "R2 rising sweep", mode_o, int'(released));
      end
      for (int c = 135; c >= 100; c--) begin
         sup = 10'(c);
         @(negedge clk);
         if (c < FALL) released = 0;
         check((mode_o != 2'd0) == released, "R3 falling sweep", mode_o, int'(released));
      end
      for (int c = 100; c <= RISE; c++) begin
         sup = 10'(c);
         @(negedge clk);
         check(mode_o == 2'd0, "R2 stays locked", mode_o, 0);
      end
      check(gate_o == 1'b0, "R1 gate while locked", gate_o, 0);
      check(int'(period_o) == PMAX, "R1 period while locked", period_o, PMAX);

      lo = 1'b1; hi = 1'b0;
      sup = 10'd200;
      have_prev = 0;
      run_hold("first");

      p = dn(PMAX);
      for (int i = 0; i < 40; i++) begin
         next_pulse(p, 2, "R6 ramp down");
         if (p == PMIN) break;
         p = dn(p);
      end
      next_pulse(PMIN, 2, "R6 floor");
      next_pulse(PMIN, 2, "R6 floor");

      lo = 1'b1; hi = 1'b1;
      for (int i = 0; i < 3; i++) next_pulse(PMIN, 2, "R8 both flags");

      lo = 1'b0; hi = 1'b1;
      p = up(PMIN);
      for (int i = 0; i < 40; i++) begin
         next_pulse(p, 2, "R7 ramp up");
         if (p == PMAX) break;
         if (p >= 100 && p < 120) begin
            lo = 1'b0; hi = 1'b0;
            next_pulse(p, 2, "R8 neither flag");
            next_pulse(p, 2, "R8 neither flag");
            hi = 1'b1;
         end
         p = up(p);
      end
      next_pulse(PMAX, 2, "R7 ceiling");
      next_pulse(PMAX, 2, "R7 ceiling");

      lo = 1'b0; hi = 1'b0;
      for (int v = 0; v < 256; v = (v < 30) ? v + 1 : v + 9) begin
         vin = 8'(v);
         vin_eff = v;
         next_pulse(PMAX, 2, "R9 line sweep");
      end

      lo = 1'b1;
      vin = 8'd100; vin_eff = 100;
      for (int i = 0; i < 4; i++) next_pulse(dn(i == 0 ? PMAX : (i == 1 ? dn(PMAX) : (i == 2 ? dn(dn(PMAX)) : dn(dn(dn(PMAX)))))) , 2, "R6 second ramp");
      wait_rise("R4 pre");
      sup = 10'd0;
      @(negedge clk);
      check(gate_o == 1'b0, "R4 gate drop", gate_o, 0);
      check(mode_o == 2'd0, "R4 mode locked", mode_o, 0);
      check(int'(period_o) == PMAX, "R4 period reset", period_o, PMAX);
      repeat (5) @(negedge clk);
      sup = 10'd200;
      have_prev = 0;
      run_hold("R4 replay");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule